// File: doc/BRIEF.md
# Switchable Gshare Branch Direction Predictor

This block guesses the direction of conditional branches for a small in-order core. It is looked up in the decode stage and trained from the execute stage. A single mode bit chooses the algorithm. With the bit high, the block runs a gshare scheme. A table of two-bit saturating counters is indexed by the word-address bits of the program counter XORed with a register of recent branch outcomes. With the bit low, every branch is predicted not-taken, and the table and history stay untouched, so their power can be gated away.

The table sits behind a single access port. In a cycle where training writes a counter, a lookup cannot read it. That lookup is answered statically instead: a branch that jumps backwards is predicted taken, and one that jumps forwards is predicted not-taken. The branch target itself comes from the decode stage's own adder and is not handled here.

The mode bit is sampled into a register. The prediction algorithm follows that register. The permission to train opens one cycle after the algorithm turns on and closes with it. This mirrors a gated clock that is unlocked one cycle after the mode change.

Top module: `bpred_switch`

## Requirements
- R1: After a synchronous reset, every counter holds 1 (weakly not-taken), the history is 0 and the algorithm is off. The first gshare lookup of any branch after enabling therefore predicts not-taken.
- R2: A gshare lookup reads the counter at index PC[9:2] XOR history[7:0]. It predicts taken when that counter is 2 or 3.
- R3: An accepted training increments the counter at PC[9:2] XOR history when the outcome is taken and decrements it otherwise. The counter saturates at 3 and at 0.
- R4: Each accepted training shifts the history left by one, with the new outcome (1 = taken) entering bit 0. No other event changes the history.
- R5: A valid lookup in a cycle with an accepted training predicts taken exactly when the branch offset is negative (backward flag = 1).
- R6: Training has priority over a lookup in the same cycle. Its counter and history update take effect even though the lookup was valid.
- R7: While the algorithm is off, the prediction is not-taken for every lookup.
- R8: While the algorithm is off, training requests are ignored. The counters and the history keep their values and are visible again after re-enabling.
- R9: The mode bit is sampled at each clock edge, and the algorithm follows it from the next cycle. Training is accepted only from the second cycle after enabling on, so a training request in the first enabled cycle is dropped.
- R10: When no lookup is requested, the prediction output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en_i | input | 1 | 1 selects gshare, 0 selects always-not-taken with state frozen |
| lk_valid_i | input | 1 | Decode-stage lookup request |
| lk_pc_i | input | IDX_W (8) | Program counter bits 9:2 of the looked-up branch |
| lk_back_i | input | 1 | 1 when the branch offset is negative |
| tr_valid_i | input | 1 | Execute-stage resolved-branch training request |
| tr_pc_i | input | IDX_W (8) | Program counter bits 9:2 of the resolved branch |
| tr_taken_i | input | 1 | Resolved outcome, 1 = taken |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
The bench targets counters held at their limits. A design that wraps instead of saturating would flip a strongly biased branch to the opposite direction. It drives lookups that coincide with training, in both offset directions. A design that read the table on such a cycle, or let the lookup block the write, would predict from a stale counter or lose the update. The two-step enable sequence is tested as well. A design that trained in the first enabled cycle, or kept training after the bit dropped, would leave counters and history different from what the bench expects when the table is read again. A long run of outcomes driven by a shift register checks that the history returns to the same index patterns that the bench computes.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_INIT = ctr_t'(1);
    localparam ctr_t CTR_TOP  = ctr_t'((1 << CTR_W) - 1);
    localparam ctr_t CTR_BOT  = ctr_t'(0);

    // encoding is {algorithm on, training clock open}
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_DRAIN = 2'b01,
        MODE_WAKE  = 2'b10,
        MODE_ON    = 2'b11
    } mode_e;

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t r;
        if (taken) r = (c == CTR_TOP) ? c : c + ctr_t'(1);
        else       r = (c == CTR_BOT) ? c : c - ctr_t'(1);
        return r;
    endfunction

    function automatic logic ctr_taken(input ctr_t c);
        return c[CTR_W-1];
    endfunction

endpackage

// File: rtl/bp_mode_ctl.sv
module bp_mode_ctl
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_req_i,
    output logic algo_on_o,
    output logic clk_open_o
);
    mode_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_OFF;
        else     state_q <= mode_e'({en_req_i, state_q[1]});
    end

    assign algo_on_o  = (state_q == MODE_WAKE) || (state_q == MODE_ON);
    assign clk_open_o = (state_q == MODE_ON)   || (state_q == MODE_DRAIN);

    // R9: training stays locked in the first enabled cycle
    p_wake_locked_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(algo_on_o) |-> !clk_open_o);

    // R9: training clock still open for one cycle after the algorithm stops
    p_drain_open_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(algo_on_o) |-> clk_open_o);

endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              taken_i,
    output logic [HIST_W-1:0] hist_o
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)          hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
    end

    assign hist_o = hist_q;

    p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(hist_o));

    p_hist_shift_r4: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (hist_o[0] == $past(taken_i)) &&
                    (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])));

endmodule

// File: rtl/bp_pht.sv
module bp_pht
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wa_i,
    input  logic             wt_i,
    input  logic [IDX_W-1:0] ra_i,
    output ctr_t             rd_o
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t             mem_q [ENTRIES];
    logic [IDX_W-1:0] port_addr;

    // one access port: a write steals it from the read
    assign port_addr = we_i ? wa_i : ra_i;
    assign rd_o      = mem_q[port_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= CTR_INIT;
        end else if (we_i) begin
            mem_q[port_addr] <= ctr_step(rd_o, wt_i);
        end
    end

    p_pht_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> (mem_q[$past(ra_i)] == $past(rd_o)));

    p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
        (we_i && wt_i && mem_q[wa_i] == CTR_TOP) |=> (mem_q[$past(wa_i)] == CTR_TOP));

    p_sat_bot_r3: assert property (@(posedge clk) disable iff (rst)
        (we_i && !wt_i && mem_q[wa_i] == CTR_BOT) |=> (mem_q[$past(wa_i)] == CTR_BOT));

endmodule

// File: rtl/bpred_switch.sv
module bpred_switch
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en_i,
    input  logic             lk_valid_i,
    input  logic [IDX_W+1:2] lk_pc_i,
    input  logic             lk_back_i,
    input  logic             tr_valid_i,
    input  logic [IDX_W+1:2] tr_pc_i,
    input  logic             tr_taken_i,
    output logic             pred_taken_o
);
    logic             algo_on;
    logic             clk_open;
    logic             train_fire;
    logic [IDX_W-1:0] hist;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] tr_idx;
    ctr_t             ctr_rd;

    bp_mode_ctl u_mode (
        .clk        (clk),
        .rst        (rst),
        .en_req_i   (mode_en_i),
        .algo_on_o  (algo_on),
        .clk_open_o (clk_open)
    );

    // inputs isolated unless both the algorithm and the training clock are on
    assign train_fire = tr_valid_i && algo_on && clk_open;
    assign lk_idx     = lk_pc_i ^ hist;
    assign tr_idx     = tr_pc_i ^ hist;

    bp_history #(.HIST_W(IDX_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .shift_i (train_fire),
        .taken_i (tr_taken_i),
        .hist_o  (hist)
    );

    bp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk  (clk),
        .rst  (rst),
        .we_i (train_fire),
        .wa_i (tr_idx),
        .wt_i (tr_taken_i),
        .ra_i (lk_idx),
        .rd_o (ctr_rd)
    );

    always_comb begin
        if (!lk_valid_i || !algo_on) pred_taken_o = 1'b0;
        else if (train_fire)         pred_taken_o = lk_back_i;
        else                         pred_taken_o = ctr_taken(ctr_rd);
    end

    p_off_not_taken_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(mode_en_i) |-> !pred_taken_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_i |-> !pred_taken_o);

    p_collide_static_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid_i && tr_valid_i && algo_on && clk_open) |-> (pred_taken_o == lk_back_i));

endmodule

// File: tb/sim_bpred_switch.sv
module sim_bpred_switch;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int ENTRIES    = 1 << IDX_W;

    typedef struct packed {
        logic             en;
        logic             lv;
        logic [IDX_W-1:0] lpc;
        logic             lb;
        logic             tv;
        logic [IDX_W-1:0] tpc;
        logic             tt;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 8'h40, 1'b0, 1'b1, 8'h40, 1'b1},
        '{1'b1, 1'b1, 8'h40, 1'b1, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h41, 1'b1},
        '{1'b1, 1'b1, 8'h41, 1'b0, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 8'h42, 1'b1, 1'b1, 8'h42, 1'b0},
        '{1'b1, 1'b1, 8'h42, 1'b0, 1'b1, 8'h42, 1'b1},
        '{1'b1, 1'b1, 8'h43, 1'b0, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h43, 1'b1},
        '{1'b1, 1'b1, 8'h43, 1'b1, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 8'h44, 1'b0, 1'b1, 8'h44, 1'b1},
        '{1'b1, 1'b1, 8'h44, 1'b0, 1'b1, 8'h44, 1'b1},
        '{1'b1, 1'b1, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h01, 1'b0},
        '{1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b0, 8'h10, 1'b1, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_en = 1'b0;
    logic             lk_v = 1'b0;
    logic [IDX_W+1:2] lk_pc = '0;
    logic             lk_back = 1'b0;
    logic             tr_v = 1'b0;
    logic [IDX_W+1:2] tr_pc = '0;
    logic             tr_t = 1'b0;
    logic             pred;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpred_switch #(.IDX_W(IDX_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .mode_en_i    (mode_en),
        .lk_valid_i   (lk_v),
        .lk_pc_i      (lk_pc),
        .lk_back_i    (lk_back),
        .tr_valid_i   (tr_v),
        .tr_pc_i      (tr_pc),
        .tr_taken_i   (tr_t),
        .pred_taken_o (pred)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model built from the requirements
    logic [1:0]       m_pht [ENTRIES];
    logic [IDX_W-1:0] m_hist;
    logic             m_alg;
    logic             m_open;

    task automatic m_reset();
        for (int i = 0; i < ENTRIES; i++) m_pht[i] = 2'd1;
        m_hist = '0;
        m_alg  = 1'b0;
        m_open = 1'b0;
    endtask

    task automatic cyc(input logic en, input logic lv, input logic [IDX_W-1:0] lpc,
                       input logic lb, input logic tv, input logic [IDX_W-1:0] tpc,
                       input logic tt, input string tag);
        logic             fire;
        logic             exp;
        logic [IDX_W-1:0] ti;
        string            t;
        @(negedge clk);
        mode_en = en; lk_v = lv; lk_pc = lpc; lk_back = lb;
        tr_v = tv; tr_pc = tpc; tr_t = tt;
        #1;
        fire = tv && m_alg && m_open;
        if (!lv || !m_alg) exp = 1'b0;
        else if (fire)     exp = lb;
        else               exp = m_pht[lpc ^ m_hist][1];
        t = tag;
        if (t == "") begin
            if (!lv)        t = "R10";
            else if (!m_alg) t = "R7";
            else if (fire)   t = "R5";
            else             t = "R2";
        end
        n_cmp++;
        if (pred !== exp) begin
            n_bad++;
            $display("FAIL %s: pred_taken_o actual=%b expected=%b (lk_pc=%h tr_pc=%h)",
                     t, pred, exp, lpc, tpc);
        end
        if (fire) begin
            ti = tpc ^ m_hist;
            if (tt && m_pht[ti] != 2'd3)  m_pht[ti] = m_pht[ti] + 2'd1;
            if (!tt && m_pht[ti] != 2'd0) m_pht[ti] = m_pht[ti] - 2'd1;
            m_hist = {m_hist[IDX_W-2:0], tt};
        end
        m_open = m_alg;
        m_alg  = en;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        m_reset();
        // reset state, R1: output quiet while reset is held
        mode_en = 1'b1; lk_v = 1'b1; lk_back = 1'b1; tr_v = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            n_cmp++;
            if (pred !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: pred_taken_o during reset actual=%b expected=0", pred);
            end
        end
        @(negedge clk);
        rst = 1'b0; mode_en = 1'b0; lk_v = 1'b0; tr_v = 1'b0;

        // R7 then R9: enable, algorithm on one cycle later, training locked in it
        cyc(1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
        cyc(1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, "R9");
        cyc(1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, "R1");
        cyc(1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b1, "R5");
        cyc(1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, "R5");

        // R3/R6: a long taken streak drives history to all ones and saturates
        for (int i = 0; i < 12; i++)
            cyc(1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 8'h11, 1'b1, "R6");
        cyc(1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, "R3");
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, "R10");
        for (int i = 0; i < 8; i++)
            cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h55, 1'b1, "R10");
        cyc(1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, "R4");

        // R3: not-taken streak saturates at zero
        for (int i = 0; i < 11; i++)
            cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h22, 1'b0, "R10");
        cyc(1'b1, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "R4");

        // R8: disable, train heavily, re-enable, table must be unchanged
        cyc(1'b0, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, 1'b0, "R2");
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 1'b1, 8'h22, 1'b1, 1'b1, 8'h22, 1'b1, "R7");
        cyc(1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 8'h22, 1'b1, "R7");
        cyc(1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 8'h22, 1'b1, "R9");
        cyc(1'b1, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, 1'b0, "R8");
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "R8");

        // table walk
        for (int v = 0; v < NVEC; v++)
            cyc(VEC[v].en, VEC[v].lv, VEC[v].lpc, VEC[v].lb, VEC[v].tv,
                VEC[v].tpc, VEC[v].tt, "");

        // long mixed run from a shift register
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            cyc(lfsr[15:13] != 3'b000, lfsr[0], {4'h5, lfsr[4:1]}, lfsr[9],
                lfsr[10] | lfsr[11], {4'h5, lfsr[8:5]}, lfsr[12] ^ lfsr[3], "");
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule